// File: doc/BRIEF.md
# TDM Serial Port with DSP Intercept

This block links a set of internal audio sample streams to an external DSP over one time-division-multiplexed serial link. The serial clock comes in from outside. From that clock the port builds a fixed frame of twelve 16-bit slots and marks each frame with a one-clock sync pulse. Slot 0 carries a tag word that tells the DSP which streams want replacement data. Slots 1 to 11 carry one internal stream each, so the DSP can watch every stream.

The DSP returns a frame of the same shape. Its slot 0 holds per-stream valid flags and its slots 1 to 11 hold replacement samples. A stream takes the DSP's sample in place of its own only under three conditions. Intercept must be enabled for that stream. The port must have requested data for that stream in the frame before. The returned valid flag must be set. The chosen sample for every stream is presented in parallel at the start of the next frame, with a one-clock strobe.

Top module: `tdm_intercept_port`

## Requirements
- R1: One frame lasts exactly 192 serial clocks, made of 12 slots of 16 bits each, and frames follow each other with no gap.
- R2: `fsync` is high for exactly one clock per frame, during the last bit period of slot 11, which is the period just before the first bit of slot 0. It is high while reset is asserted and in the first period after reset is released, so the first frame starts right after that period.
- R3: `sdOut` sends each slot MSB first and changes only after rising clock edges. `sdIn` is sampled on falling clock edges.
- R4: The slot 0 word sent out holds the request for stream i at bit i+1 (bits 11..1). Bit 0 and bits 15..12 are zero. The request for stream i is `needSmp[i] & interceptEn[i]`, sampled at the rising edge that starts the frame.
- R5: Slot i+1 sent out carries `smpIn` stream i (bits `[16*i +: 16]`), sampled at the rising edge that starts the frame.
- R6: At the rising edge that starts each frame, `outStb` goes high for one clock and `outSmp` and `subUsed` are updated. For each stream, `outSmp` takes the internal sample `smpIn` sampled at that edge unless the stream is substituted.
- R7: Stream i is substituted when all three hold: the slot 0 word received in frame N has bit i+1 set; the port requested stream i in frame N-1; `interceptEn[i]` is high at the end of received slot 0. Then, at the start of frame N+1, `outSmp` stream i equals the word received in slot i+1 of frame N, and `subUsed[i]` is 1.
- R8: A received valid bit for a stream whose `interceptEn` bit is low at the end of received slot 0 is ignored: that stream gets the internal sample and its `subUsed` bit is 0.
- R9: A received valid bit for a stream that the port did not request in the previous frame is ignored, even when intercept is enabled. The bits of the received slot 0 word outside 11..1 are ignored as well.
- R10: While reset is asserted, `sdOut`, `outStb`, `outSmp` and `subUsed` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| interceptEn | input | 11 | Per-stream intercept enable |
| needSmp | input | 11 | Per-stream request for a replacement sample from the DSP |
| smpIn | input | 176 | Internal samples, stream i at bits [16*i +: 16] |
| sdIn | input | 1 | Serial data from the DSP |
| fsync | output | 1 | Frame sync pulse |
| sdOut | output | 1 | Serial data to the DSP |
| outSmp | output | 176 | Selected sample per stream, same layout as smpIn |
| outStb | output | 1 | One-clock strobe when outSmp is updated |
| subUsed | output | 11 | Per-stream flag: the DSP sample was taken |

## Verification
The bench aims at the request-to-valid window. If a design checked the valid bits against the current frame's requests instead of the previous frame's, it would substitute a stream whose request was only just raised. If it skipped the intercept gate, a disabled stream would take the DSP word. The received tag word carries extra bits outside the valid field, so a design that decodes the field at the wrong position substitutes the wrong streams. Slot 11 data arrives on the same edge that ends the frame, so a design that stores it one cycle late hands out a stale sample for the last stream. Off-by-one errors in the sync position or in the slot load order show up at once in the bit-by-bit compare.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             frameEnd;
    logic             slotEnd;
    logic [IDX_W-1:0] slotIdx;
    logic [IDX_W-1:0] bitIdx;
  } tdmStrobe_t;
endpackage

// File: rtl/tdm_frame_ctl.sv
module tdm_frame_ctl
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 16,
  parameter int SLOTS  = 12
) (
  input  logic       clk,
  input  logic       rstN,
  output logic       fsync,
  output tdmStrobe_t strb
);
  localparam int BW = $clog2(SLOT_W);
  localparam int SW = $clog2(SLOTS);
  localparam logic [BW-1:0] BIT_LAST  = BW'(SLOT_W - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);

  logic [BW-1:0] bitCnt;
  logic [SW-1:0] slotCnt;
  logic lastBit;

  assign lastBit = (bitCnt == BIT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= BIT_LAST;
      slotCnt <= SLOT_LAST;
    end else begin
      bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      if (lastBit) slotCnt <= (slotCnt == SLOT_LAST) ? '0 : slotCnt + 1'b1;
    end
  end

  assign strb.slotEnd  = lastBit;
  assign strb.frameEnd = lastBit && (slotCnt == SLOT_LAST);
  assign strb.slotIdx  = IDX_W'(slotCnt);
  assign strb.bitIdx   = IDX_W'(bitCnt);
  assign fsync         = strb.frameEnd;

  // R1: the frame counter wraps to the first bit of slot 0
  p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameEnd |=> (slotCnt == '0 && bitCnt == '0));

  // R2: sync lasts a single clock
  p_fsync_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    fsync |=> !fsync);
endmodule

// File: rtl/tdm_datapath.sv
module tdm_datapath
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 16,
  parameter int SLOTS  = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tdmStrobe_t              strb,
  input  logic [SLOTS-2:0]        interceptEn,
  input  logic [SLOTS-2:0]        needSmp,
  input  logic [(SLOTS-1)*SLOT_W-1:0] smpIn,
  input  logic                    sdIn,
  output logic                    sdOut,
  output logic [(SLOTS-1)*SLOT_W-1:0] outSmp,
  output logic                    outStb,
  output logic [SLOTS-2:0]        subUsed
);
  localparam int NS  = SLOTS - 1;
  localparam int SIW = $clog2(SLOTS);

  logic [SLOT_W-1:0] txShift;
  logic [SLOT_W-1:0] smpHold [NS];
  logic [SLOT_W-2:0] rxShift;
  logic              rxBit;
  logic [SLOT_W-1:0] rxWord;
  logic [SLOT_W-1:0] rxData [NS];
  logic [SLOT_W-1:0] rxDataNext [NS];
  logic [NS-1:0]     rxValid, reqCur, reqPrev, reqNew;
  logic [SLOT_W-1:0] tagWord;
  logic [SIW-1:0]    slotNow;

  assign slotNow = strb.slotIdx[SIW-1:0];
  assign rxWord  = {rxShift, rxBit};
  assign reqNew  = needSmp & interceptEn;
  assign sdOut   = txShift[SLOT_W-1];

  always_comb begin
    tagWord = '0;
    tagWord[NS:1] = reqNew;
  end

  // receive bit on the falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) rxBit <= 1'b0;
    else       rxBit <= sdIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxValid <= '0;
      reqCur  <= '0;
      reqPrev <= '0;
      outStb  <= 1'b0;
      subUsed <= '0;
    end else begin
      rxShift <= rxWord[SLOT_W-2:0];
      outStb  <= strb.frameEnd;
      if (strb.frameEnd) begin
        txShift <= tagWord;
        reqPrev <= reqCur;
        reqCur  <= reqNew;
        subUsed <= rxValid;
        rxValid <= '0;
      end else if (strb.slotEnd) begin
        txShift <= smpHold[slotNow];
        if (slotNow == '0)
          rxValid <= rxWord[NS:1] & reqPrev & interceptEn;
      end else begin
        txShift <= {txShift[SLOT_W-2:0], 1'b0};
      end
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_stream
    assign rxDataNext[s] = (strb.slotEnd && slotNow == SIW'(s + 1)) ? rxWord : rxData[s];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxData[s]  <= '0;
        smpHold[s] <= '0;
        outSmp[s*SLOT_W +: SLOT_W] <= '0;
      end else begin
        rxData[s] <= rxDataNext[s];
        if (strb.frameEnd) begin
          smpHold[s] <= smpIn[s*SLOT_W +: SLOT_W];
          outSmp[s*SLOT_W +: SLOT_W] <= rxValid[s] ? rxDataNext[s]
                                                   : smpIn[s*SLOT_W +: SLOT_W];
        end
      end
    end
  end

  // R4: padding bits of the outgoing tag word stay low
  p_tag_pad_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.slotIdx == '0 && (strb.bitIdx < IDX_W'(SLOT_W - 1 - NS)
                            || strb.bitIdx == IDX_W'(SLOT_W - 1))) |-> !sdOut);

  // R6: the update strobe follows a frame end
  p_stb_after_sync_r6: assert property (@(posedge clk) disable iff (!rstN)
    outStb |-> $past(strb.frameEnd));

  // R6: the update strobe is one clock wide
  p_stb_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    outStb |=> !outStb);
endmodule

// File: rtl/tdm_intercept_port.sv
module tdm_intercept_port
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 16,
  parameter int SLOTS  = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SLOTS-2:0]            interceptEn,
  input  logic [SLOTS-2:0]            needSmp,
  input  logic [(SLOTS-1)*SLOT_W-1:0] smpIn,
  input  logic                        sdIn,
  output logic                        fsync,
  output logic                        sdOut,
  output logic [(SLOTS-1)*SLOT_W-1:0] outSmp,
  output logic                        outStb,
  output logic [SLOTS-2:0]            subUsed
);
  tdmStrobe_t strb;

  tdm_frame_ctl #(.SLOT_W(SLOT_W), .SLOTS(SLOTS)) i_ctl (
    .clk(clk), .rstN(rstN), .fsync(fsync), .strb(strb)
  );

  tdm_datapath #(.SLOT_W(SLOT_W), .SLOTS(SLOTS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .interceptEn(interceptEn), .needSmp(needSmp), .smpIn(smpIn), .sdIn(sdIn),
    .sdOut(sdOut), .outSmp(outSmp), .outStb(outStb), .subUsed(subUsed)
  );
endmodule

// File: tb/test_tdm_intercept_port.sv
`timescale 1ns/1ps
module test_tdm_intercept_port;
  localparam int NS = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] interceptEn = '0, needSmp = '0;
  logic [NS*16-1:0] smpIn = '0;
  logic sdIn = 1'b0;
  logic fsync, sdOut, outStb;
  logic [NS*16-1:0] outSmp;
  logic [NS-1:0] subUsed;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  tdm_intercept_port i_tdm_intercept_port (
    .clk(clk), .rstN(rstN), .interceptEn(interceptEn), .needSmp(needSmp),
    .smpIn(smpIn), .sdIn(sdIn), .fsync(fsync), .sdOut(sdOut),
    .outSmp(outSmp), .outStb(outStb), .subUsed(subUsed)
  );

  // behavioural reference
  int pos = 191;
  logic [15:0] txM [12];
  logic [15:0] curRx [12];
  logic [15:0] nextRx [12];
  logic [15:0] expOut [NS];
  logic [NS-1:0] reqCurM = '0, reqPrevM = '0, accM = '0, expUsed = '0;
  logic [NS-1:0] offM = '0, noReqM = '0, expOff = '0, expNoReq = '0;

  initial for (int k = 0; k < 12; k++) begin
    txM[k] = '0; curRx[k] = '0; nextRx[k] = '0;
  end
  initial for (int i = 0; i < NS; i++) expOut[i] = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      pos = 191; reqCurM = '0; reqPrevM = '0; accM = '0;
    end else begin
      if (pos == 15) begin
        accM   = curRx[0][11:1] & reqPrevM & interceptEn;
        offM   = curRx[0][11:1] & ~interceptEn;
        noReqM = curRx[0][11:1] & interceptEn & ~reqPrevM;
      end
      if (pos == 191) begin
        for (int i = 0; i < NS; i++)
          expOut[i] = accM[i] ? curRx[i+1] : smpIn[i*16 +: 16];
        expUsed = accM; expOff = offM; expNoReq = noReqM;
        accM = '0; offM = '0; noReqM = '0;
        reqPrevM = reqCurM;
        reqCurM = needSmp & interceptEn;
        txM[0] = {4'b0, reqCurM, 1'b0};
        for (int k = 1; k < 12; k++) txM[k] = smpIn[(k-1)*16 +: 16];
        for (int k = 0; k < 12; k++) curRx[k] = nextRx[k];
        pos = 0;
      end else pos++;
    end
  end

  // DSP side drives its bits after the rising edge
  always @(posedge clk) begin
    #1;
    sdIn = curRx[pos/16][15 - (pos % 16)];
  end

  task automatic chk(input bit ok, input string msg, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", msg, got, exp);
    end
  endtask

  // compare away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      chk(sdOut == 1'b0, "R10 sdOut in reset", 64'(sdOut), 0);
      chk(outStb == 1'b0 && subUsed == '0 && outSmp == '0, "R10 outputs in reset",
          64'({outStb, subUsed}), 0);
      chk(fsync == 1'b1, "R2 fsync in reset", 64'(fsync), 1);
    end else begin
      chk(fsync == (pos == 191), "R1 R2 fsync position", 64'(fsync), 64'(pos == 191));
      chk(sdOut == txM[pos/16][15 - (pos % 16)],
          (pos < 16) ? "R3 R4 tag bit" : "R3 R5 sample bit",
          64'(sdOut), 64'(txM[pos/16][15 - (pos % 16)]));
      chk(outStb == (pos == 0), "R6 strobe", 64'(outStb), 64'(pos == 0));
      if (pos == 0) begin
        for (int i = 0; i < NS; i++) begin
          string tag;
          if (expUsed[i])       tag = "R7 substituted";
          else if (expOff[i])   tag = "R8 intercept off";
          else if (expNoReq[i]) tag = "R9 no request";
          else                  tag = "R6 internal";
          chk(outSmp[i*16 +: 16] == expOut[i], $sformatf("%s outSmp[%0d]", tag, i),
              64'(outSmp[i*16 +: 16]), 64'(expOut[i]));
          chk(subUsed[i] == expUsed[i], $sformatf("%s subUsed[%0d]", tag, i),
              64'(subUsed[i]), 64'(expUsed[i]));
        end
      end
    end
  end

  // set up the inputs of the frame that starts at the next boundary
  task automatic nextFrame(input logic [NS-1:0] need, input logic [NS-1:0] ien,
                           input logic [NS-1:0] vld);
    do @(negedge clk); while (pos != 191);
    #1;
    needSmp = need;
    interceptEn = ien;
    for (int i = 0; i < NS; i++) smpIn[i*16 +: 16] = 16'($urandom);
    nextRx[0] = {4'hF, vld, 1'b1};
    for (int k = 1; k < 12; k++) nextRx[k] = 16'($urandom);
  endtask

  initial begin
    #12.2 rstN = 1'b1;
    nextFrame('1, '1, '0);
    nextFrame('1, '1, '1);            // R7 all streams substituted
    nextFrame(11'h0F0, '1, '1);       // still requested in the frame before
    nextFrame('1, '1, '1);            // R9 only streams 4..7 requested before
    nextFrame('1, 11'h555, '1);       // R8 intercept off for some
    nextFrame('1, '1, 11'h2AA);
    nextFrame(11'h400, '1, 11'h400);  // R7 last stream, slot 11 edge
    nextFrame('0, '1, '1);
    nextFrame('1, '1, '1);            // R9 nothing requested before
    for (int n = 0; n < 4; n++)
      nextFrame(11'($urandom), 11'($urandom), 11'($urandom));
    nextFrame('0, '0, '0);
    nextFrame('0, '0, '0);
    do @(negedge clk); while (pos != 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired R1 got=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule